// File: doc/BRIEF.md
# Sign-Extending Precision Unpacker

This block sits between a line-wide neuron or weight memory and a compute array that is fed one fixed-width beat per cycle. Memory lines hold signed elements packed at a storage width, and the compute array wants signed elements at an operating width that is the same or a power-of-two multiple of it. The block captures one line in a holding register. It then emits one output beat per accepted handshake. Each beat holds the next group of elements from the line, and each element is sign-extended to the operating width.

A line at storage width M fills N/M beats at operating width N. Elements are taken from the low end of the held line. A new line is accepted only in the cycle the final beat of the current one is taken, or while the block is empty. A one-cycle line request pulse marks that final beat, so that an upstream fetcher can start the next read. When M equals N, lines pass straight through at one line per beat with no bubble.

Top module: `prec_unpack`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block is empty after that edge: `beat_valid` is 0, `mem_ready` is 1 and `line_req` is 0.
- R2: A line accepted at storage code s and operating code o yields exactly 2^(o-s) beats, and then `beat_valid` drops unless a new line was taken.
- R3: Width codes are 2 bits: 0 means 2 bits, 1 means 4, 2 means 8 and 3 means 16. Beat j at storage width M and operating width N carries, in bits [i*N+N-1 : i*N], the line element at bits [(j*(LINE_W/N)+i)*M+M-1 : (j*(LINE_W/N)+i)*M], for i from 0 to LINE_W/N-1.
- R4: Each element is sign-extended from M to N bits, so the most negative M-bit value becomes the most negative M-bit value in N bits (for example, 2'b10 at N=16 becomes 16'hFFFE), and non-negative values are zero-extended.
- R5: `line_req` is high exactly in the cycle the final beat of a line is accepted (`beat_valid` and `beat_ready` both high), and at no other time.
- R6: While `beat_valid` is high and `beat_ready` is low, `beat_valid` and `beat_data` hold their values into the next cycle.
- R7: When the storage code equals the operating code, each line appears unchanged on `beat_data` as a single beat. A new line offered during that beat's acceptance is taken in the same cycle and appears on the next cycle.
- R8: `mem_ready` is high when the block is empty, or in the cycle the final beat is accepted. At all other times it is low, and `mem_valid` and `mem_line` have no effect on the beats being emitted.
- R9: The configuration codes must satisfy operating code ≥ storage code, and they stay unchanged while a line is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_store_w | input | 2 | Storage element width code |
| cfg_oper_w | input | 2 | Operating element width code |
| mem_valid | input | 1 | Memory line offered |
| mem_ready | output | 1 | Block can take a line this cycle |
| mem_line | input | LINE_W | Packed memory line |
| beat_valid | output | 1 | Output beat present |
| beat_ready | input | 1 | Compute side takes the beat |
| beat_data | output | LINE_W | Unpacked, sign-extended beat |
| line_req | output | 1 | Pulse on acceptance of a line's final beat |

## Verification
A line taken at a rising edge shows up as beat 0 on `beat_data` right after that edge. Each accepted beat moves the output to the next group after the edge. `line_req` and `mem_ready` follow `beat_ready` in the same cycle, with no register in between. The bench therefore drives its inputs at the falling edge and samples all outputs one nanosecond later, before the next rising edge. It compares against the element that each requirement predicts for that exact beat index, including beats held across random stalls.

// File: rtl/prec_unpack_pkg.sv
// Package: shared width codes and helpers for the precision unpacker.
// Assumes element widths are limited to 2, 4, 8 and 16 bits.
package prec_unpack_pkg;

    // Number of supported element widths and log2 of the largest expansion ratio.
    localparam int NUM_WIDTHS = 4;
    localparam int RATIO_LOG_MAX = NUM_WIDTHS - 1;
    localparam int IDX_W = 3;

    typedef enum logic [1:0] {
        WC_2  = 2'd0,
        WC_4  = 2'd1,
        WC_8  = 2'd2,
        WC_16 = 2'd3
    } wcode_t;

    // Element width in bits for a width code.
    function automatic int code_bits(input int code);
        return 2 << code;
    endfunction

    // Log2 of beats per line; zero for an illegal (narrowing) pair.
    function automatic logic [1:0] ratio_log(input wcode_t store_c, input wcode_t oper_c);
        if (oper_c >= store_c) return 2'(oper_c - store_c);
        return 2'd0;
    endfunction

endpackage

// File: rtl/pu_line_reg.sv
// Line holding register: captures one memory line when load is high.
// Assumes load is only raised when the controller grants a new line.
module pu_line_reg #(
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] din,
    output logic [LINE_W-1:0] dout
);

    logic [LINE_W-1:0] held_q;

    // Capture a fresh line on load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    held_q <= '0;
        else if (load) held_q <= din;
    end

    assign dout = held_q;

endmodule

// File: rtl/pu_ctrl.sv
// Beat sequencer: tracks whether a line is held and which beat is current.
// It grants a new line when empty or when the final beat is accepted.
// Assumes the width codes are stable while a line is held.
module pu_ctrl
    import prec_unpack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  wcode_t           store_c,
    input  wcode_t           oper_c,
    input  logic             mem_valid,
    input  logic             beat_ready,
    output logic             load,
    output logic             mem_ready,
    output logic             busy,
    output logic             line_done,
    output logic [IDX_W-1:0] beat_idx,
    output logic [1:0]       ratio_k
);

    logic             full_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic             take;

    // Derive the final beat index and the handshake terms.
    always_comb begin
        ratio_k   = ratio_log(store_c, oper_c);
        last_idx  = IDX_W'((4'd1 << ratio_k) - 4'd1);
        take      = full_q && beat_ready;
        line_done = take && (idx_q == last_idx);
        mem_ready = !full_q || line_done;
        load      = mem_valid && mem_ready;
    end

    // Advance the beat counter and the occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            idx_q  <= '0;
        end else if (load) begin
            full_q <= 1'b1;
            idx_q  <= '0;
        end else if (line_done) begin
            full_q <= 1'b0;
            idx_q  <= '0;
        end else if (take) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign busy     = full_q;
    assign beat_idx = idx_q;

endmodule

// File: rtl/pu_extract.sv
// Beat extractor: shifts the held line down to the current beat's group,
// then sign-extends every element from the storage to the operating width.
// One candidate beat is built per legal width pair and the pair selects it.
// Assumes operating code >= storage code; narrowing pairs yield zero.
module pu_extract
    import prec_unpack_pkg::*;
#(
    parameter int LINE_W = 256
) (
    input  logic [LINE_W-1:0] line,
    input  logic [IDX_W-1:0]  beat_idx,
    input  logic [1:0]        ratio_k,
    input  wcode_t            store_c,
    input  wcode_t            oper_c,
    output logic [LINE_W-1:0] beat
);

    localparam int LOG_LW = $clog2(LINE_W);
    localparam int SHW    = LOG_LW + 1;

    logic [SHW-1:0]    shamt;
    logic [LINE_W-1:0] shifted;
    logic [LINE_W-1:0] cand [NUM_WIDTHS*NUM_WIDTHS];

    // Bit offset of the current beat's group: beat index times LINE_W / ratio.
    always_comb begin
        shamt   = SHW'(beat_idx) << (LOG_LW - 32'(ratio_k));
        shifted = line >> shamt;
    end

    // Build one sign-extended candidate beat per (storage, operating) pair.
    for (genvar sm = 0; sm < NUM_WIDTHS; sm++) begin : g_store
        for (genvar om = 0; om < NUM_WIDTHS; om++) begin : g_oper
            localparam int MW = 2 << sm;
            localparam int NW = 2 << om;
            if (om >= sm) begin : g_legal
                for (genvar e = 0; e < LINE_W / NW; e++) begin : g_elem
                    if (NW == MW) begin : g_pass
                        assign cand[sm*NUM_WIDTHS+om][e*NW +: NW] = shifted[e*MW +: MW];
                    end else begin : g_sext
                        assign cand[sm*NUM_WIDTHS+om][e*NW +: NW] =
                            {{(NW-MW){shifted[e*MW+MW-1]}}, shifted[e*MW +: MW]};
                    end
                end
            end else begin : g_illegal
                assign cand[sm*NUM_WIDTHS+om] = '0;
            end
        end
    end

    // Select the candidate for the configured width pair.
    always_comb begin
        beat = cand[{store_c, oper_c}];
    end

endmodule

// File: rtl/prec_unpack.sv
// Top of the precision unpacker: one memory line in, 2^(oper-store) beats
// out, each beat holding LINE_W/N sign-extended elements from the line's
// low end upward. Assumes the configuration changes only while empty.
module prec_unpack
    import prec_unpack_pkg::*;
#(
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_store_w,
    input  logic [1:0]        cfg_oper_w,
    input  logic              mem_valid,
    output logic              mem_ready,
    input  logic [LINE_W-1:0] mem_line,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [LINE_W-1:0] beat_data,
    output logic              line_req
);

    wcode_t            store_c;
    wcode_t            oper_c;
    logic              load;
    logic [LINE_W-1:0] held;
    logic [IDX_W-1:0]  beat_idx;
    logic [1:0]        ratio_k;

    // Map the raw configuration pins onto the width code type.
    always_comb begin
        store_c = wcode_t'(cfg_store_w);
        oper_c  = wcode_t'(cfg_oper_w);
    end

    pu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_c    (store_c),
        .oper_c     (oper_c),
        .mem_valid  (mem_valid),
        .beat_ready (beat_ready),
        .load       (load),
        .mem_ready  (mem_ready),
        .busy       (beat_valid),
        .line_done  (line_req),
        .beat_idx   (beat_idx),
        .ratio_k    (ratio_k)
    );

    pu_line_reg #(.LINE_W(LINE_W)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (mem_line),
        .dout  (held)
    );

    pu_extract #(.LINE_W(LINE_W)) u_extract (
        .line     (held),
        .beat_idx (beat_idx),
        .ratio_k  (ratio_k),
        .store_c  (store_c),
        .oper_c   (oper_c),
        .beat     (beat_data)
    );

endmodule

// File: rtl/pu_chk.sv
// Checker for the precision unpacker, bound to the top module.
// Watches only the port-level handshake and counts beats per line.
module pu_chk #(
    parameter int LINE_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_store_w,
    input logic [1:0]        cfg_oper_w,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [LINE_W-1:0] beat_data,
    input logic              line_req
);

    logic [3:0] beats_seen;
    logic [4:0] beats_due;

    // Count beats accepted since the current line was taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                       beats_seen <= '0;
        else if (mem_valid && mem_ready)  beats_seen <= '0;
        else if (beat_valid && beat_ready) beats_seen <= beats_seen + 1'b1;
    end

    // Beats a line should yield for the present configuration.
    always_comb begin
        beats_due = (cfg_oper_w >= cfg_store_w) ? (5'd1 << (cfg_oper_w - cfg_store_w)) : 5'd1;
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> !beat_valid && mem_ready && !line_req);

    // R2
    beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |-> (5'(beats_seen) + 5'd1 == beats_due));

    // R5
    req_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |-> beat_valid && beat_ready && mem_ready);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_data));

    // R8
    no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !line_req |-> !mem_ready);

    // R9
    cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> cfg_oper_w >= cfg_store_w);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && $past(beat_valid) && !$past(line_req) |->
            $stable(cfg_store_w) && $stable(cfg_oper_w));

endmodule

bind prec_unpack pu_chk #(.LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_store_w (cfg_store_w),
    .cfg_oper_w  (cfg_oper_w),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .beat_valid  (beat_valid),
    .beat_ready  (beat_ready),
    .beat_data   (beat_data),
    .line_req    (line_req)
);

// File: tb/prec_unpack_bench.sv
// Bench: random and directed lines for every legal width pair, with random
// stalls; outputs compared against a bench-side element model.
module prec_unpack_bench;

    localparam int LW = 256;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_store_w = '0;
    logic [1:0]    cfg_oper_w = '0;
    logic          mem_valid = 1'b0;
    logic          mem_ready;
    logic [LW-1:0] mem_line = '0;
    logic          beat_valid;
    logic          beat_ready = 1'b0;
    logic [LW-1:0] beat_data;
    logic          line_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prec_unpack #(.LINE_W(LW)) u_prec_unpack (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_store_w (cfg_store_w),
        .cfg_oper_w  (cfg_oper_w),
        .mem_valid   (mem_valid),
        .mem_ready   (mem_ready),
        .mem_line    (mem_line),
        .beat_valid  (beat_valid),
        .beat_ready  (beat_ready),
        .beat_data   (beat_data),
        .line_req    (line_req)
    );

    // Expected beat j: element i of width n from line element j*(LW/n)+i of width m.
    function automatic logic [LW-1:0] exp_beat(input logic [LW-1:0] line,
                                               input int m, input int n, input int j);
        logic [LW-1:0] r = '0;
        int per = LW / n;
        for (int i = 0; i < per; i++)
            for (int b = 0; b < n; b++)
                r[i*n+b] = line[(j*per+i)*m + ((b < m) ? b : m-1)];
        return r;
    endfunction

    function automatic logic [LW-1:0] rand_line();
        logic [LW-1:0] r;
        for (int w = 0; w < LW/32; w++) r[w*32 +: 32] = $urandom;
        return r;
    endfunction

    // Every element holds the most negative value for width m.
    function automatic logic [LW-1:0] min_line(input int m);
        logic [LW-1:0] r = '0;
        for (int e = 0; e < LW/m; e++) r[e*m+m-1] = 1'b1;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Send one line and drain its beats with random stalls.
    task automatic send_line(input int sc, input int oc, input logic [LW-1:0] line,
                             input int stall_max);
        int m = 2 << sc;
        int n = 2 << oc;
        int nb = n / m;
        cfg_store_w = 2'(sc);
        cfg_oper_w  = 2'(oc);
        mem_valid   = 1'b1;
        mem_line    = line;
        beat_ready  = 1'b0;
        #1;
        chk(mem_ready == 1'b1, "R8 ready when empty", LW'(mem_ready), LW'(1));
        step();
        for (int j = 0; j < nb; j++) begin
            int stalls = (stall_max == 0) ? 0 : int'($urandom % (stall_max + 1));
            for (int s = 0; s < stalls; s++) begin
                beat_ready = 1'b0;
                mem_valid  = 1'b1;
                mem_line   = rand_line();
                #1;
                chk(beat_valid && beat_data == exp_beat(line, m, n, j),
                    "R6 R8 held beat under stall", beat_data, exp_beat(line, m, n, j));
                chk(!mem_ready && !line_req, "R8 R5 busy during stall",
                    LW'({mem_ready, line_req}), LW'(0));
                step();
            end
            beat_ready = 1'b1;
            mem_valid  = 1'b0;
            #1;
            chk(beat_valid && beat_data == exp_beat(line, m, n, j),
                "R3 R4 beat content", beat_data, exp_beat(line, m, n, j));
            chk(line_req == (j == nb-1), "R5 line_req timing",
                LW'(line_req), LW'(j == nb-1));
            chk(mem_ready == (j == nb-1), "R8 ready on final beat",
                LW'(mem_ready), LW'(j == nb-1));
            step();
        end
        beat_ready = 1'b0;
        #1;
        chk(!beat_valid, "R2 no extra beat", LW'(beat_valid), LW'(0));
        step();
    endtask

    // Watchdog: a hung run is one failed check, then the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [LW-1:0] la, lb;
        void'($urandom(32'd2024));
        @(negedge clk);
        step();
        step();
        #1;
        // R1 reset state
        chk(!beat_valid && mem_ready && !line_req, "R1 reset state",
            LW'({beat_valid, mem_ready, line_req}), LW'(3'b010));
        step();
        rst_n = 1'b1;
        step();

        // R3 R4 R9: every legal pair, directed extremes then random lines.
        for (int sc = 0; sc < 4; sc++) begin
            for (int oc = sc; oc < 4; oc++) begin
                send_line(sc, oc, min_line(2 << sc), 0);
                send_line(sc, oc, ~min_line(2 << sc), 1);
                for (int r = 0; r < 6; r++) send_line(sc, oc, rand_line(), 3);
            end
        end

        // R4 explicit: 2-bit 10 widened to 16 bits is FFFE.
        cfg_store_w = 2'd0;
        cfg_oper_w  = 2'd3;
        mem_valid   = 1'b1;
        mem_line    = {{(LW-2){1'b0}}, 2'b10};
        beat_ready  = 1'b0;
        step();
        mem_valid = 1'b0;
        #1;
        chk(beat_data[15:0] == 16'hFFFE, "R4 most negative 2-bit to 16-bit",
            LW'(beat_data[15:0]), LW'(16'hFFFE));
        for (int j = 0; j < 8; j++) begin
            beat_ready = 1'b1;
            step();
        end
        beat_ready = 1'b0;
        #1;
        chk(!beat_valid, "R2 eight beats for 2-to-16", LW'(beat_valid), LW'(0));
        step();

        // R7: pass-through, back-to-back lines with no bubble.
        for (int sc = 0; sc < 4; sc++) begin
            la = rand_line();
            lb = rand_line();
            cfg_store_w = 2'(sc);
            cfg_oper_w  = 2'(sc);
            mem_valid   = 1'b1;
            mem_line    = la;
            beat_ready  = 1'b1;
            step();
            mem_line = lb;
            #1;
            chk(beat_valid && beat_data == la, "R7 pass-through first line", beat_data, la);
            chk(mem_ready && line_req, "R7 same-cycle refill",
                LW'({mem_ready, line_req}), LW'(2'b11));
            step();
            mem_valid = 1'b0;
            #1;
            chk(beat_valid && beat_data == lb, "R7 pass-through second line", beat_data, lb);
            step();
            beat_ready = 1'b0;
            #1;
            chk(!beat_valid, "R7 drained", LW'(beat_valid), LW'(0));
            step();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule